// File: doc/BRIEF.md
# Power status and wakeup flag register

This block is the register pair a power-management unit exposes to software. A control word at offset 0x0 enables the supply-voltage monitor, picks its threshold level and arms the wakeup pin. It also carries two write-one-to-clear strobes for the event flags. A read-only status word at offset 0x4 reports three things: a standby flag, a wakeup flag and the gated monitor output. Both flags are sticky and set by hardware.

The wakeup flag can be set by any of five single-cycle event pulses: two alarms, tamper, timestamp and a periodic timer. The asynchronous wakeup pin can also set it. The pin first passes through a flop synchronizer and is then gated by its enable bit. A rising edge of the gated level counts as a wakeup, so turning the enable on while the pin is already high also counts as one. A standby-entry pulse sets the standby flag and stops the monitor. The monitor output then reads zero until software enables the monitor again. The active-low asynchronous reset acts as the power-on reset.

Top module: `pwr_status_regs`

## Requirements
- R1: Reads at offset 0x4 return the monitor output in bit 2, the standby flag in bit 1 and the wakeup flag in bit 0, with bits 31:3 reading 0. Reads at any offset other than 0x0 and 0x4 return 0.
- R2: The control word at offset 0x0 holds the monitor enable in bit 0, the 3-bit threshold level in bits 3:1 and the pin enable in bit 4. All three read back as written. `mon_en_o` and `lvl_sel_o` follow the stored fields.
- R3: Control bits 8 (clear wakeup) and 9 (clear standby) act only as write strobes and always read back as 0.
- R4: A `standby_i` pulse sets the standby flag at the next clock edge. The flag stays set until a control write with bit 9 = 1, or a reset.
- R5: A pulse on any bit of `evt_src_i` sets the wakeup flag at the next clock edge.
- R6: With the pin enable set, a rising edge on `wkup_pin_i` sets the wakeup flag three clock edges later (two synchronizer stages plus the flag register). With the pin enable clear, the pin has no effect.
- R7: Setting the pin enable while the synchronized pin is already high sets the wakeup flag one edge after the write.
- R8: The wakeup flag stays set until a control write with bit 8 = 1, or a reset. A control write with bit 8 = 0 leaves it set.
- R9: When a set event and a clear strobe for the same flag arrive in the same cycle, the flag ends up set.
- R10: The monitor output is the comparator input registered one cycle, ANDed with the monitor enable. A value of 1 means the supply is below the threshold.
- R11: A `standby_i` pulse clears the monitor enable and the monitor output. Standby takes priority over a simultaneous control write. The output then reads 0 until the enable is written to 1 again.
- R12: Writes to the status offset change no state.
- R13: After reset, both words read 0 and `mon_en_o` and `lvl_sel_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| addr_i | input | ADDR_W | Register byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational from the address |
| standby_i | input | 1 | Standby-entry pulse |
| wkup_pin_i | input | 1 | Asynchronous wakeup pin level |
| evt_src_i | input | N_SRC | Alarm A, alarm B, tamper, timestamp and periodic wakeup pulses |
| cmp_below_i | input | 1 | Comparator result, 1 when the supply is below the threshold |
| mon_en_o | output | 1 | Monitor enable to the comparator |
| lvl_sel_o | output | 3 | Threshold level to the comparator |

## Verification
The bench builds the block with its defaults: ADDR_W = 4, DATA_W = 32, N_SRC = 5 and SYNC_STAGES = 2. With these values the bench can pulse each of the five wakeup sources one at a time. The two-stage synchronizer gives a fixed three-edge delay from pin to flag, which the reference model reproduces with a short queue. The 4-bit address space also reaches the unmapped offset 0x8.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int unsigned CTRL_OFS      = 0;
  localparam int unsigned STAT_OFS      = 4;
  localparam int unsigned LVL_W         = 3;
  localparam int unsigned CTRL_MON_EN   = 0;
  localparam int unsigned CTRL_LVL_LSB  = 1;
  localparam int unsigned CTRL_PIN_EN   = CTRL_LVL_LSB + LVL_W;
  localparam int unsigned CTRL_CLR_WKUP = 8;
  localparam int unsigned CTRL_CLR_STBY = 9;
  localparam int unsigned STAT_WKUP     = 0;
  localparam int unsigned STAT_STBY     = 1;
  localparam int unsigned STAT_MON      = 2;

  typedef struct packed {
    logic             pin_en;
    logic [LVL_W-1:0] lvl;
    logic             mon_en;
  } pwr_ctrl_t;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= 1'b0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= 1'b0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int unsigned N_SRC       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             pin_en_i,
  input  logic [N_SRC-1:0] src_i,
  output logic             evt_o
);
  logic pin_s;
  logic gated;
  logic gated_prev_q;

  pwr_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  // gating before edge detect also catches enable-while-high
  assign gated = pin_s & pin_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gated_prev_q <= 1'b0;
    else         gated_prev_q <= gated;
  end

  assign evt_o = (gated & ~gated_prev_q) | (|src_i);
endmodule

// File: rtl/pwr_sticky_flag.sv
module pwr_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/pwr_status_regs.sv
module pwr_status_regs
  import pwr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned N_SRC       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              standby_i,
  input  logic              wkup_pin_i,
  input  logic [N_SRC-1:0]  evt_src_i,
  input  logic              cmp_below_i,
  output logic              mon_en_o,
  output logic [LVL_W-1:0]  lvl_sel_o
);
  pwr_ctrl_t ctrl_q;
  logic      sel_ctrl, sel_stat, ctrl_wr;
  logic      clr_wkup, clr_stby;
  logic      wake_evt;
  logic      wkup_flag, stby_flag;
  logic      mon_q;
  logic      wdata_unused;

  assign sel_ctrl = (addr_i == ADDR_W'(CTRL_OFS));
  assign sel_stat = (addr_i == ADDR_W'(STAT_OFS));
  assign ctrl_wr  = we_i & sel_ctrl;
  assign clr_wkup = ctrl_wr & wdata_i[CTRL_CLR_WKUP];
  assign clr_stby = ctrl_wr & wdata_i[CTRL_CLR_STBY];
  assign wdata_unused = ^{wdata_i[DATA_W-1:CTRL_CLR_STBY+1],
                          wdata_i[CTRL_CLR_WKUP-1:CTRL_PIN_EN+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.mon_en <= wdata_i[CTRL_MON_EN];
        ctrl_q.lvl    <= wdata_i[CTRL_LVL_LSB +: LVL_W];
        ctrl_q.pin_en <= wdata_i[CTRL_PIN_EN];
      end
      if (standby_i) ctrl_q.mon_en <= 1'b0;  // monitor stops in standby
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mon_q <= 1'b0;
    else if (standby_i) mon_q <= 1'b0;
    else                mon_q <= ctrl_q.mon_en & cmp_below_i;
  end

  pwr_wake_detect #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) i_wake (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (wkup_pin_i),
    .pin_en_i(ctrl_q.pin_en),
    .src_i   (evt_src_i),
    .evt_o   (wake_evt)
  );

  pwr_sticky_flag i_wkup_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wake_evt),
    .clr_i (clr_wkup),
    .flag_o(wkup_flag)
  );

  pwr_sticky_flag i_stby_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (standby_i),
    .clr_i (clr_stby),
    .flag_o(stby_flag)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[CTRL_MON_EN]               = ctrl_q.mon_en;
      rdata_o[CTRL_LVL_LSB +: LVL_W]     = ctrl_q.lvl;
      rdata_o[CTRL_PIN_EN]               = ctrl_q.pin_en;
    end else if (sel_stat) begin
      rdata_o[STAT_MON]  = mon_q;
      rdata_o[STAT_STBY] = stby_flag;
      rdata_o[STAT_WKUP] = wkup_flag;
    end
  end

  assign mon_en_o  = ctrl_q.mon_en;
  assign lvl_sel_o = ctrl_q.lvl;
endmodule

// File: rtl/pwr_status_chk.sv
module pwr_status_chk
  import pwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SRC  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              standby_i,
  input logic [N_SRC-1:0]  evt_src_i,
  input logic              wkup_flag_i,
  input logic              stby_flag_i,
  input logic              mon_en_i,
  input logic              mon_i
);
  logic wr_ctrl;
  assign wr_ctrl = we_i && (addr_i == ADDR_W'(CTRL_OFS));

  AST_STAT_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(STAT_OFS)) |-> (rdata_o[DATA_W-1:STAT_MON+1] == '0)); // R1
  AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(CTRL_OFS)) |-> (rdata_o[CTRL_CLR_STBY:CTRL_CLR_WKUP] == 2'b00)); // R3
  AST_STBY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> stby_flag_i); // R4
  AST_STBY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stby_flag_i && !(wr_ctrl && wdata_i[CTRL_CLR_STBY])) |=> stby_flag_i); // R4
  AST_SRC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_src_i) |=> wkup_flag_i); // R5
  AST_WKUP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wkup_flag_i && !(wr_ctrl && wdata_i[CTRL_CLR_WKUP])) |=> wkup_flag_i); // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|evt_src_i) && wr_ctrl && wdata_i[CTRL_CLR_WKUP]) |=> wkup_flag_i); // R9
  AST_MON_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_en_i |=> !mon_i); // R10
  AST_STBY_STOPS_MON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (!mon_en_i && !mon_i)); // R11
endmodule

bind pwr_status_regs pwr_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .standby_i  (standby_i),
  .evt_src_i  (evt_src_i),
  .wkup_flag_i(wkup_flag),
  .stby_flag_i(stby_flag),
  .mon_en_i   (ctrl_q.mon_en),
  .mon_i      (mon_q)
);

// File: tb/test_pwr_status_regs.sv
`timescale 1ns/1ps
module test_pwr_status_regs;
  localparam int AW = 4, DW = 32, NS = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          standby = 1'b0;
  logic          pin = 1'b0;
  logic [NS-1:0] src = '0;
  logic          cmp = 1'b0;
  logic          mon_en;
  logic [2:0]    lvl_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_status_regs i_pwr_status_regs (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .standby_i(standby), .wkup_pin_i(pin), .evt_src_i(src),
    .cmp_below_i(cmp), .mon_en_o(mon_en), .lvl_sel_o(lvl_sel)
  );

  // behavioural reference model
  bit       m_mon_en, m_pin_en, m_wkup, m_stby, m_mon, m_gprev;
  bit [2:0] m_lvl;
  bit       m_sync[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mon_en = 0; m_pin_en = 0; m_wkup = 0; m_stby = 0; m_mon = 0; m_gprev = 0;
      m_lvl = 0; m_sync = '{0, 0};
    end else begin
      bit wr, pin_s, g, ev;
      wr    = we && (addr == 0);
      pin_s = m_sync[$];
      g     = pin_s && m_pin_en;
      ev    = (g && !m_gprev) || (src != 0);
      m_gprev = g;
      m_sync.push_front(pin);
      void'(m_sync.pop_back());
      if (ev) m_wkup = 1; else if (wr && wdata[8]) m_wkup = 0;
      if (standby) m_stby = 1; else if (wr && wdata[9]) m_stby = 0;
      m_mon = standby ? 0 : (m_mon_en && cmp);
      if (wr) begin m_mon_en = wdata[0]; m_lvl = wdata[3:1]; m_pin_en = wdata[4]; end
      if (standby) m_mon_en = 0;
    end
  end

  function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    if (a == 0)      v = {27'd0, m_pin_en, m_lvl, m_mon_en};
    else if (a == 4) v = {29'd0, m_mon, m_stby, m_wkup};
    return v;
  endfunction

  // per-cycle comparison, away from edges
  always begin
    @(negedge clk); #1;
    if (rst_ni && !done) begin
      logic [DW-1:0] e, d;
      string tag;
      e = exp_rd(addr);
      d = e ^ rdata;
      checks++;
      if (d != 0) begin
        errors++;
        if (addr == 4) tag = d[0] ? "R5" : d[1] ? "R4" : d[2] ? "R10" : "R1";
        else tag = (addr == 0) ? "R2" : "R1";
        $display("FAIL %s cycle compare addr=%0h actual=%h expected=%h", tag, addr, rdata, e);
      end
      checks++;
      if (mon_en !== m_mon_en || lvl_sel !== m_lvl) begin
        errors++;
        $display("FAIL R2 outputs actual=%b/%0d expected=%b/%0d", mon_en, lvl_sel, m_mon_en, m_lvl);
      end
    end
  end

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; we = 1; wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    @(negedge clk); addr = a; we = 0; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    idle(3); rst_ni = 1;
    rd(4, 0, "R13 status after reset");
    rd(0, 0, "R13 control after reset");
    chk("R13 outputs after reset", {28'd0, lvl_sel, mon_en}, 0);

    wr(0, 32'h0B);
    rd(0, 32'h0B, "R2 control readback");
    chk("R2 lvl_sel_o", 32'(lvl_sel), 5);
    chk("R2 mon_en_o", 32'(mon_en), 1);

    cmp = 1; idle(2);
    rd(4, 32'h4, "R10 monitor below");

    for (int k = 0; k < NS; k++) begin
      @(negedge clk); src = NS'(1) << k;
      @(negedge clk); src = '0;
      rd(4, 32'h5, $sformatf("R5 source %0d", k));
      if (k == 0) begin
        wr(4, 32'hFFFF_FFFF);
        rd(4, 32'h5, "R12 status write ignored");
        wr(0, 32'h0B);
        rd(4, 32'h5, "R8 write without clear");
      end
      wr(0, 32'h10B);
      rd(4, 32'h4, "R8 clear wakeup");
    end

    cmp = 0; idle(2);
    rd(4, 0, "R10 monitor above");

    @(negedge clk); pin = 1; idle(5);
    rd(4, 0, "R6 pin ignored while disabled");
    @(negedge clk); pin = 0; idle(3);
    wr(0, 32'h1B);
    @(negedge clk); pin = 1;
    idle(1);
    rd(4, 0, "R6 sync latency not yet elapsed");
    idle(2);
    rd(4, 32'h1, "R6 pin edge sets wakeup");
    wr(0, 32'h11B);
    idle(2);
    rd(4, 0, "R6 steady high pin no new event");
    rd(0, 32'h1B, "R3 clear bits read zero");
    wr(0, 32'h0B); idle(2);
    wr(0, 32'h1B); idle(1);
    rd(4, 32'h1, "R7 enable while pin high");
    wr(0, 32'h11B);
    @(negedge clk); pin = 0;

    cmp = 1; idle(2);
    rd(4, 32'h4, "R10 monitor before standby");
    @(negedge clk); standby = 1;
    @(negedge clk); standby = 0;
    rd(4, 32'h2, "R4 standby flag set");
    rd(0, 32'h1A, "R11 enable cleared by standby");
    idle(3);
    rd(4, 32'h2, "R11 monitor stays zero");
    wr(0, 32'h1B); idle(1);
    rd(4, 32'h6, "R10 monitor after re-enable");
    wr(0, 32'h21B);
    rd(4, 32'h4, "R4 clear standby");

    @(negedge clk); standby = 1; src = 5'b00100; addr = 0; we = 1; wdata = 32'h31B;
    @(negedge clk); standby = 0; src = '0; we = 0; wdata = '0;
    rd(4, 32'h3, "R9 set wins over clear");
    rd(0, 32'h1A, "R11 standby beats control write");

    rd(8, 0, "R1 unmapped offset");

    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    rd(4, 0, "R13 reset clears flags");
    rd(0, 0, "R13 reset clears control");
    idle(2);
    summary();
  end
endmodule